// File: doc/BRIEF.md
# Balanced 4b/6b Serial Line Encoder

This block turns a byte stream into a serial bit stream whose 6-bit codewords all contain three ones and three zeros. The line therefore has a constant DC mean and frequent transitions, so a receiver can recover the clock from the data and the pair can be transformer-coupled. Each accepted byte is split into two nibbles. The low nibble goes out first and the high nibble second, and each nibble is mapped through a fixed one-to-one table onto sixteen of the twenty balanced 6-bit values. The code is fixed-disparity, so the encoder keeps no disparity history and each nibble has exactly one encoding.

Two of the four remaining balanced values serve as in-band control symbols. A sync word is sent in a burst after reset, so that a receiver can find word alignment. An idle word fills the line whenever no byte is waiting, so the line never stops toggling. The bit rate is set by a clock-enable input. Each enable pulse puts one bit on the line, most significant bit first.

Top module: `enc46_tx`

## Requirements
- R1: Every 6-bit word placed on the line has exactly three ones.
- R2: Nibble value n is sent as the n-th balanced 6-bit value in ascending numeric order, counting from zero. For example, 0 is 000111, 1 is 001011, 10 is 100011 and 15 is 101100.
- R3: An accepted byte produces its low-nibble word first and then its high-nibble word, back to back.
- R4: After reset the line carries SYNC_WORDS (default 8) sync words 111000, and `inReady` stays low until the last bit of the last sync word is being shifted out.
- R5: When a low-nibble slot comes up with `inValid` low, or during any slot after the sync burst where no byte is accepted, the idle word 110001 is sent.
- R6: Words are sent MSB first, with one bit per cycle in which `bitEn` is high. `lineOut` does not change on a clock edge where `bitEn` is low.
- R7: `inReady` is high only in a cycle where `bitEn` is high, the last bit of a word is being sent, the sync burst is over and the next word is a low-nibble slot. A byte transfers on a rising edge where `inValid` and `inReady` are both high.
- R8: Bytes offered continuously go out with no idle word between them, and `inData` has no effect outside the transfer cycle.
- R9: During and just after reset, `lineOut` is 1 (the MSB of the sync word) and `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Transmit bit enable; one line bit per high cycle |
| inData | input | 8 | Byte to send |
| inValid | input | 1 | `inData` holds a byte |
| inReady | output | 1 | Encoder takes the byte on this edge |
| lineOut | output | 1 | Serial line bit |

## Verification
A bit counter that is out of step would break word alignment, and the bench sees this within one word as words that are unbalanced or not in the table. A nibble phase that is wrong would swap or repeat nibbles, or slip an idle word into a byte, at the next byte that is sent. A sync counter that is wrong would show up in the first few words after reset as a burst of the wrong length, or as `inReady` rising too early. The bench decodes the line back into whole words and compares them with words it computes from the nibble table.

// File: rtl/enc46_pkg.sv
package enc46_pkg;

  localparam int WORD_W = 6;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [WORD_W-1:0] SYNC_CODE = 6'b111000;
  localparam logic [WORD_W-1:0] IDLE_CODE = 6'b110001;

  typedef enum logic [1:0] {
    SEL_SYNC = 2'd0,
    SEL_IDLE = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } wordSel_e;

  typedef struct packed {
    logic     shift;
    logic     load;
    wordSel_e sel;
    logic     grabHi;
  } encStrobe_t;

  // n-th balanced word in ascending order
  function automatic logic [WORD_W-1:0] dataCode(input logic [NIB_W-1:0] nib);
    logic [WORD_W-1:0] res;
    logic              found;
    int                rank;
    res   = '0;
    found = 1'b0;
    rank  = 0;
    for (int v = 0; v < (1 << WORD_W); v++) begin
      if ($countones(v[WORD_W-1:0]) == WORD_W / 2) begin
        if (!found && rank == int'(nib)) begin
          res   = v[WORD_W-1:0];
          found = 1'b1;
        end
        rank++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/enc46_ctrl.sv
module enc46_ctrl
  import enc46_pkg::*;
#(
  parameter int SYNC_WORDS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       inValid,
  output logic       inReady,
  output encStrobe_t strobe
);

  localparam int CNT_W  = $clog2(WORD_W);
  localparam int SYNC_W = $clog2(SYNC_WORDS + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_W - 1);
  localparam logic [SYNC_W-1:0] SYNC_INIT = SYNC_W'(SYNC_WORDS - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [SYNC_W-1:0] syncLeft;
  logic              phaseHi;
  logic              loadNow;
  logic              syncActive;

  always_comb begin
    loadNow    = bitEn && (bitCnt == LAST_BIT);
    syncActive = (syncLeft != '0);
    inReady    = loadNow && !syncActive && !phaseHi;

    strobe.shift  = bitEn && !loadNow;
    strobe.load   = loadNow;
    strobe.grabHi = inReady && inValid;
    if (syncActive)   strobe.sel = SEL_SYNC;
    else if (phaseHi) strobe.sel = SEL_HI;
    else if (inValid) strobe.sel = SEL_LO;
    else              strobe.sel = SEL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      syncLeft <= SYNC_INIT;
      phaseHi  <= 1'b0;
    end else if (bitEn) begin
      if (loadNow) begin
        bitCnt <= '0;
        if (syncActive) syncLeft <= syncLeft - 1'b1;
        else            phaseHi  <= phaseHi ? 1'b0 : inValid;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  AST_HI_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (phaseHi && !inReady)); // R3

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady); // R7

endmodule

// File: rtl/enc46_datapath.sv
module enc46_datapath
  import enc46_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        strobe,
  input  logic [BYTE_W-1:0] inData,
  output logic              lineOut
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic [NIB_W-1:0]  hiNib;

  always_comb begin
    unique case (strobe.sel)
      SEL_SYNC: nextWord = SYNC_CODE;
      SEL_IDLE: nextWord = IDLE_CODE;
      SEL_LO:   nextWord = dataCode(inData[NIB_W-1:0]);
      SEL_HI:   nextWord = dataCode(hiNib);
      default:  nextWord = IDLE_CODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= SYNC_CODE;
      hiNib    <= '0;
    end else begin
      if (strobe.load)       shiftReg <= nextWord;
      else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      if (strobe.grabHi)     hiNib    <= inData[BYTE_W-1:NIB_W];
    end
  end

  assign lineOut = shiftReg[WORD_W-1];

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shift || strobe.load) |=> $stable(lineOut)); // R6

  AST_LOAD_BALANCED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ($countones(shiftReg) == WORD_W / 2)); // R1

endmodule

// File: rtl/enc46_tx.sv
module enc46_tx
  import enc46_pkg::*;
#(
  parameter int SYNC_WORDS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic       lineOut
);

  encStrobe_t strobe;

  enc46_ctrl #(.SYNC_WORDS(SYNC_WORDS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .inValid (inValid),
    .inReady (inReady),
    .strobe  (strobe)
  );

  enc46_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .lineOut (lineOut)
  );

endmodule

// File: tb/enc46_tx_bench.sv
`timescale 1ns/1ps
module enc46_tx_bench;

  localparam int PERIOD   = 10;
  localparam int NSYNC    = 8;
  localparam int MAXW     = 2048;
  localparam logic [5:0] SYNC_W6 = 6'b111000;
  localparam logic [5:0] IDLE_W6 = 6'b110001;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       lineOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int   div = 1;
  int   divCnt = 0;
  logic [5:0] words [0:MAXW-1];
  int   nWords = 0;
  logic [5:0] acc = '0;
  int   accBits = 0;
  int   bitsTotal = 0;
  int   accepts = 0;
  int   readyEarly = 0;
  int   readyBad = 0;
  int   lineMoved = 0;
  logic prevEn = 1'b0;
  logic prevLine = 1'b0;
  bit   prevOk = 1'b0;

  enc46_tx #(.SYNC_WORDS(NSYNC)) u_enc46_tx (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inData(inData),
    .inValid(inValid), .inReady(inReady), .lineOut(lineOut)
  );

  always #(PERIOD/2) clk = ~clk;

  // bit enable divider
  always @(negedge clk) begin
    if (divCnt + 1 >= div) begin divCnt <= 0; bitEn <= 1'b1; end
    else begin divCnt <= divCnt + 1; bitEn <= 1'b0; end
  end

  // line monitor: sees values that apply to the next rising edge
  always @(negedge clk) begin
    #2;
    if (!rstN) begin
      nWords = 0; accBits = 0; bitsTotal = 0; accepts = 0;
      readyEarly = 0; readyBad = 0; prevOk = 1'b0;
    end else begin
      if (prevOk && !prevEn && lineOut != prevLine) lineMoved++;
      if (inReady && !bitEn) readyBad++;
      if (inReady && bitsTotal < NSYNC * 6 - 1) readyEarly++;
      if (inReady && inValid) accepts++;
      if (bitEn) begin
        acc = {acc[4:0], lineOut};
        accBits++;
        bitsTotal++;
        if (accBits == 6) begin
          if (nWords < MAXW) words[nWords] = acc;
          nWords++;
          accBits = 0;
        end
      end
      prevEn = bitEn; prevLine = lineOut; prevOk = 1'b1;
    end
  end

  function automatic logic [5:0] balCode(input int n);
    int rank = 0;
    logic [5:0] r = '0;
    for (int v = 0; v < 64; v++) begin
      if ($countones(v[5:0]) == 3) begin
        if (rank == n) r = v[5:0];
        rank++;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic doReset();
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 lineOut in reset", lineOut, 1);
    check("R9 inReady in reset", inReady, 0);
    rstN = 1'b1;
    #1;
    check("R9 lineOut after reset", lineOut, 1);
  endtask

  task automatic waitWords(input int n);
    while (nWords < n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    inData = b;
    inValid = 1'b1;
    forever begin
      #1;
      if (inReady) begin @(negedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic t_sync();
    waitWords(NSYNC + 2);
    for (int i = 0; i < NSYNC; i++) check("R4 sync word", words[i], SYNC_W6);
    check("R5 idle after sync", words[NSYNC], IDLE_W6);
    check("R5 idle after sync 2", words[NSYNC + 1], IDLE_W6);
    check("R4 no early ready", readyEarly, 0);
  endtask

  task automatic t_stream(input logic [7:0] bs [], input string tag);
    int mark, idx, acc0;
    mark = nWords;
    acc0 = accepts;
    @(negedge clk);
    foreach (bs[i]) sendByte(bs[i]);
    inValid = 1'b0;
    inData = 8'h5A;  // R8 ignored without handshake
    waitWords(mark + 2 * bs.size() + 6);
    idx = mark;
    while (idx < nWords && words[idx] == IDLE_W6) idx++;
    foreach (bs[i]) begin
      check({tag, " R2 R3 low word"}, words[idx + 2*i], balCode(int'(bs[i][3:0])));
      check({tag, " R2 R3 R8 high word"}, words[idx + 2*i + 1], balCode(int'(bs[i][7:4])));
    end
    check({tag, " R5 idle after bytes"}, words[idx + 2 * bs.size()], IDLE_W6);
    check({tag, " R7 transfers"}, accepts - acc0, bs.size());
  endtask

  task automatic t_table();
    logic [7:0] bs [];
    bs = new[8];
    for (int k = 0; k < 8; k++) bs[k] = {4'(2*k + 1), 4'(2*k)};
    t_stream(bs, "table");
    check("R2 nibble 0", balCode(0), 6'b000111);
    check("R2 nibble 15", balCode(15), 6'b101100);
  endtask

  task automatic t_final();
    int bad = 0;
    for (int i = 0; i < nWords && i < MAXW; i++)
      if ($countones(words[i]) != 3) bad++;
    check("R1 balanced words", bad, 0);
    check("R6 line held without enable", lineMoved, 0);
    check("R7 ready only with enable", readyBad, 0);
  endtask

  initial begin
    logic [7:0] a [];
    a = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h96};
    div = 1;
    doReset();
    t_sync();
    t_stream(a, "div1");
    t_table();
    t_final();
    div = 3;
    doReset();
    t_sync();
    t_stream(a, "div3");
    a = '{8'h71};
    t_stream(a, "single");
    t_final();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule